// File: doc/BRIEF.md
# Four-Channel PWM Controller with Word Register Interface

This block holds four independent pulse-width modulators behind a 32-bit register port that accepts only word-aligned accesses. Each channel owns a 16-bit period value and a 16-bit compare threshold. Each channel also has a four-bit control field that starts or stops it and can invert its output. A channel advances one step on each single-cycle pulse of its tick enable, which an external prescaler stage supplies. The prescaler and selector settings are stored here and driven out to that stage.

While a channel runs, its output is high for compare+1 ticks of every period+1 ticks. A zero period forces the output low, and a compare value at or above the period forces it high. The invert bit complements the result in every state, including while the channel is stopped. New period and compare values wait for the end of the current period before they take effect, so a running waveform never shows a shortened or stretched cycle. A stopped channel holds its counter at zero and begins a fresh period on the cycle it is started.

Top module: `quad_pwm_ctrl`

## Requirements
- R1: After reset every register reads zero and all four PWM outputs are low.
- R2: Word offsets: prescaler 0x00, selector 0x04, control 0x08. Channel n has its period at 0x0C+12n, its compare at 0x10+12n and a read-only count at 0x14+12n, and the count reports the channel's live tick counter. Prescaler and selector read back as written and appear on their output ports. Any other offset reads zero.
- R3: A period or compare write whose value exceeds 65535 stores 65535.
- R4: Channel n's control field is four bits wide and sits at bit offset 0, 8, 12 or 16 for n = 0 to 3. Inside the field, bit 0 is enable, bit 2 is invert and bit 3 is continuous mode. The channel runs only when enable and continuous mode are both 1. Otherwise it is stopped and its output equals its invert bit.
- R5: A running channel with 0 < compare < period drives its output high for compare+1 ticks out of every period+1 ticks, and advances only on its own tick enable.
- R6: A running channel with period 0 holds its output low.
- R7: A running channel whose compare is greater than or equal to its period holds its output high.
- R8: The invert bit complements the output of a running channel as well as a stopped one.
- R9: Writes to the count registers, to 0x3C and 0x40, and to 0x44 through 0x50 change no state, and these offsets read zero except for the count.
- R10: A running channel keeps its current period until the counter wraps, and only then loads new period and compare values. A channel that is started begins counting from zero.
- R11: A write whose address has bits [1:0] not equal to 00 is ignored, and a read at such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| tick_en | input | 4 | Per-channel single-cycle tick enables from the prescaler stage |
| presc_cfg | output | 32 | Stored prescaler register, sent to the prescaler stage |
| clksel_cfg | output | 32 | Stored selector register, sent to the prescaler stage |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The assertions assume at most one bus access per cycle, with the strobe, address and data held steady across the sampling edge. They also assume each tick enable is a clean synchronous level that is sampled only at a clock edge. The counter-bound and hold-period properties further take for granted that nothing but reset and the tick disturbs a running counter. The stimulus changes the bus at falling edges and changes the tick enables one nanosecond after each rising edge, so every value is stable at the edge that samples it. It never issues a read and a write in the same cycle. Misaligned addresses appear only in the deliberate accesses that check they are ignored.

// File: rtl/pwm4_pkg.sv
// Shared constants for the four-channel PWM controller: register offsets,
// control-field bit positions and the per-channel field placement.
package pwm4_pkg;

    localparam int unsigned OFF_PRESC   = 'h00;
    localparam int unsigned OFF_SEL     = 'h04;
    localparam int unsigned OFF_CTRL    = 'h08;
    localparam int unsigned OFF_CH0     = 'h0C;
    localparam int unsigned CH_STRIDE   = 12;
    localparam int unsigned SUB_PERIOD  = 0;
    localparam int unsigned SUB_COMPARE = 4;
    localparam int unsigned SUB_COUNT   = 8;

    localparam int unsigned CB_EN  = 0;
    localparam int unsigned CB_INV = 2;
    localparam int unsigned CB_TOG = 3;

    // Bit offset of a channel's control field: 0 for the first, then 8, 12, 16...
    function automatic int unsigned ctrl_lsb(input int unsigned ch);
        return (ch == 0) ? 0 : (4 * ch + 4);
    endfunction

endpackage

// File: rtl/pwm_channel.sv
// One PWM channel. Counts 0..period on each tick while running; output is
// high while count <= compare, with zero-period and compare>=period corners.
// Assumes: run/inv come straight from the control register; period_new and
// compare_new may change at any time and are loaded only at wrap or when stopped.
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             inv,
    input  logic [CNT_W-1:0] period_new,
    input  logic [CNT_W-1:0] compare_new,
    output logic [CNT_W-1:0] count,
    output logic             pwm
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act_period;
    logic [CNT_W-1:0] act_compare;
    logic             wrap;
    logic             raw;

    assign wrap = tick && (cnt == act_period);

    // Counter and shadow registers: hold at zero when stopped, reload at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            act_period  <= '0;
            act_compare <= '0;
        end else if (!run) begin
            cnt         <= '0;
            act_period  <= period_new;
            act_compare <= compare_new;
        end else if (wrap) begin
            cnt         <= '0;
            act_period  <= period_new;
            act_compare <= compare_new;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Waveform level from the active values, before inversion.
    always_comb begin
        if (!run)
            raw = 1'b0;
        else if (act_period == '0)
            raw = 1'b0;
        else if (act_compare >= act_period)
            raw = 1'b1;
        else
            raw = (cnt <= act_compare);
    end

    assign pwm   = raw ^ inv;
    assign count = cnt;

    // R10: a running channel never changes its period except at wrap.
    a_r10_hold_period: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(act_period));

    // R10: the counter never passes the active period.
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_period);

    // R4: a stopped channel holds its counter at zero on the following cycle.
    a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/pwm_regfile.sv
// Register file of the PWM controller: word-aligned decode, clamped period and
// compare storage, control-field extraction and a combinational read mux.
// Assumes: one access per cycle; DATA_W > CNT_W; ctrl fields fit in DATA_W.
module pwm_regfile
    import pwm4_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic [NCH-1:0][CNT_W-1:0]  live_cnt,
    output logic [DATA_W-1:0]          presc_q,
    output logic [DATA_W-1:0]          sel_q,
    output logic [NCH-1:0][CNT_W-1:0]  period_q,
    output logic [NCH-1:0][CNT_W-1:0]  compare_q,
    output logic [NCH-1:0]             run,
    output logic [NCH-1:0]             inv
);

    logic [DATA_W-1:0] ctrl_q;
    logic              aligned;
    logic              hit_presc, hit_sel, hit_ctrl;
    logic [NCH-1:0]    hit_per, hit_cmp, hit_cnt;

    // Saturate a bus value to the counter width.
    function automatic logic [CNT_W-1:0] clamp(input logic [DATA_W-1:0] v);
        return (|v[DATA_W-1:CNT_W]) ? {CNT_W{1'b1}} : v[CNT_W-1:0];
    endfunction

    assign aligned   = (addr[1:0] == 2'b00);
    assign hit_presc = aligned && (addr == ADDR_W'(OFF_PRESC));
    assign hit_sel   = aligned && (addr == ADDR_W'(OFF_SEL));
    assign hit_ctrl  = aligned && (addr == ADDR_W'(OFF_CTRL));

    // Per-channel address decode.
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            hit_per[n] = aligned && (addr == ADDR_W'(OFF_CH0 + n * CH_STRIDE + SUB_PERIOD));
            hit_cmp[n] = aligned && (addr == ADDR_W'(OFF_CH0 + n * CH_STRIDE + SUB_COMPARE));
            hit_cnt[n] = aligned && (addr == ADDR_W'(OFF_CH0 + n * CH_STRIDE + SUB_COUNT));
        end
    end

    // Register writes; misaligned and unlisted offsets fall through untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q   <= '0;
            sel_q     <= '0;
            ctrl_q    <= '0;
            period_q  <= '0;
            compare_q <= '0;
        end else if (wr_en) begin
            if (hit_presc) presc_q <= wdata;
            if (hit_sel)   sel_q   <= wdata;
            if (hit_ctrl)  ctrl_q  <= wdata;
            for (int n = 0; n < NCH; n++) begin
                if (hit_per[n]) period_q[n]  <= clamp(wdata);
                if (hit_cmp[n]) compare_q[n] <= clamp(wdata);
            end
        end
    end

    // Read mux: zero unless a decoded offset is read.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (hit_presc) rdata = presc_q;
            if (hit_sel)   rdata = sel_q;
            if (hit_ctrl)  rdata = ctrl_q;
            for (int n = 0; n < NCH; n++) begin
                if (hit_per[n]) rdata = DATA_W'(period_q[n]);
                if (hit_cmp[n]) rdata = DATA_W'(compare_q[n]);
                if (hit_cnt[n]) rdata = DATA_W'(live_cnt[n]);
            end
        end
    end

    // Control-field extraction at the irregular per-channel offsets.
    for (genvar g = 0; g < NCH; g++) begin : g_fld
        localparam int unsigned LSB = ctrl_lsb(g);
        assign run[g] = ctrl_q[LSB + CB_EN] & ctrl_q[LSB + CB_TOG];
        assign inv[g] = ctrl_q[LSB + CB_INV];

        // R3: oversize period and compare writes saturate.
        a_r3_clamp_period: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && hit_per[g] && (|wdata[DATA_W-1:CNT_W])) |=> (period_q[g] == {CNT_W{1'b1}}));
        a_r3_clamp_compare: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && hit_cmp[g] && (|wdata[DATA_W-1:CNT_W])) |=> (compare_q[g] == {CNT_W{1'b1}}));
    end

    // R11: a misaligned write leaves the configuration untouched.
    a_r11_misaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !aligned) |=> ($stable(ctrl_q) && $stable(presc_q) && $stable(sel_q)));

endmodule

// File: rtl/quad_pwm_ctrl.sv
// Top of the four-channel PWM controller: one register file and NCH channels.
// Assumes: tick_en pulses come from an external prescaler stage configured by
// presc_cfg and clksel_cfg; all inputs are synchronous to clk.
module quad_pwm_ctrl
    import pwm4_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    tick_en,
    output logic [DATA_W-1:0] presc_cfg,
    output logic [DATA_W-1:0] clksel_cfg,
    output logic [NCH-1:0]    pwm_out
);

    logic [NCH-1:0][CNT_W-1:0] live_cnt;
    logic [NCH-1:0][CNT_W-1:0] period_q;
    logic [NCH-1:0][CNT_W-1:0] compare_q;
    logic [NCH-1:0]            run;
    logic [NCH-1:0]            inv;

    pwm_regfile #(
        .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .live_cnt(live_cnt),
        .presc_q(presc_cfg), .sel_q(clksel_cfg),
        .period_q(period_q), .compare_q(compare_q),
        .run(run), .inv(inv)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .tick(tick_en[g]), .run(run[g]), .inv(inv[g]),
            .period_new(period_q[g]), .compare_new(compare_q[g]),
            .count(live_cnt[g]), .pwm(pwm_out[g])
        );
    end

endmodule

// File: tb/quad_pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module quad_pwm_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_en = '0;
    logic [31:0] presc_cfg, clksel_cfg;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [31:0] ctrl_v = '0;

    // Scoreboard queues: one entry per expected waveform measurement.
    int    q_ch[$], q_win[$], q_hi[$], q_rise[$];
    string q_tag[$];
    bit    mon_busy = 1'b0;

    quad_pwm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .presc_cfg(presc_cfg), .clksel_cfg(clksel_cfg),
        .pwm_out(pwm_out)
    );

    always #2.5 clk = ~clk;

    // Tick source: channel n pulses every n+1 cycles, changed away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            for (int n = 0; n < 4; n++) tick_en[n] = ((cyc % (n + 1)) == 0);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    function automatic int field_lsb(input int ch);
        return (ch == 0) ? 0 : 4 * ch + 4;
    endfunction

    task automatic set_nib(input int ch, input logic [3:0] nib);
        ctrl_v[field_lsb(ch) +: 4] = nib;
        bus_write(12'h008, ctrl_v);
    endtask

    // Reference model of one measurement window, taken from the requirements.
    task automatic expect_wave(input int ch, input int per, input int cmp,
                               input logic [3:0] nib, input int win, input string tag);
        int hi, rises;
        bit running;
        running = nib[0] && nib[3];
        if (!running || per == 0) begin
            hi = 0; rises = 0;
        end else if (cmp >= per) begin
            hi = win; rises = 0;
        end else begin
            hi = (win / (per + 1)) * (cmp + 1);
            rises = win / (per + 1);
        end
        if (nib[2]) hi = win - hi;
        q_ch.push_back(ch); q_win.push_back(win); q_hi.push_back(hi);
        q_rise.push_back(rises); q_tag.push_back(tag);
        do @(negedge clk); while (q_ch.size() != 0 || mon_busy);
    endtask

    // Monitor: measures high ticks and rising edges over a window of tick slots.
    initial begin
        forever begin
            int ch, win, ehi, erise, hi, rise;
            logic prev, lvl;
            string tag;
            do @(negedge clk); while (q_ch.size() == 0);
            ch = q_ch.pop_front(); win = q_win.pop_front(); ehi = q_hi.pop_front();
            erise = q_rise.pop_front(); tag = q_tag.pop_front();
            mon_busy = 1'b1;
            do @(negedge clk); while (!tick_en[ch]);
            prev = pwm_out[ch];
            hi = 0; rise = 0;
            for (int i = 0; i < win; i++) begin
                do @(negedge clk); while (!tick_en[ch]);
                lvl = pwm_out[ch];
                if (lvl) hi++;
                if (lvl && !prev) rise++;
                prev = lvl;
            end
            check({tag, " high ticks"}, hi, ehi);
            check({tag, " rising edges"}, rise, erise);
            mon_busy = 1'b0;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int mx;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        read_check("R1 ctrl", 12'h008, 0);
        read_check("R1 prescaler", 12'h000, 0);
        read_check("R1 period ch2", 12'h024, 0);
        read_check("R1 count ch0", 12'h014, 0);
        check("R1 pwm_out", 32'(pwm_out), 0);

        // R2: prescaler / selector storage and unmapped offset
        bus_write(12'h000, 32'hA5A5_0102);
        read_check("R2 prescaler readback", 12'h000, 32'hA5A5_0102);
        bus_write(12'h004, 32'h0000_4321);
        read_check("R2 selector readback", 12'h004, 32'h0000_4321);
        check("R2 presc_cfg port", presc_cfg, 32'hA5A5_0102);
        check("R2 clksel_cfg port", clksel_cfg, 32'h0000_4321);
        read_check("R2 unmapped read", 12'h060, 0);

        // R9: interrupt and watchdog-data offsets
        bus_write(12'h03C, 32'hFFFF);
        read_check("R9 irq enable offset", 12'h03C, 0);
        bus_write(12'h040, 32'h0F);
        read_check("R9 irq status offset", 12'h040, 0);
        bus_write(12'h044, 32'h1234);
        read_check("R9 watchdog data offset", 12'h044, 0);
        check("R9 outputs untouched", 32'(pwm_out), 0);

        // R5: ch0 period 5 compare 1, ch1 period 7 compare 0
        bus_write(12'h00C, 5);
        bus_write(12'h010, 1);
        read_check("R2 period ch0 readback", 12'h00C, 5);
        set_nib(0, 4'h9);
        expect_wave(0, 5, 1, 4'h9, 12, "R5 ch0");
        bus_write(12'h018, 7);
        bus_write(12'h01C, 0);
        set_nib(1, 4'h9);
        expect_wave(1, 7, 0, 4'h9, 16, "R5 ch1");

        // R6: zero period on ch2
        bus_write(12'h024, 0);
        bus_write(12'h028, 3);
        set_nib(2, 4'h9);
        expect_wave(2, 0, 3, 4'h9, 10, "R6 ch2");

        // R7: compare equal to and above period on ch3
        bus_write(12'h030, 4);
        bus_write(12'h034, 4);
        set_nib(3, 4'h9);
        expect_wave(3, 4, 4, 4'h9, 10, "R7 ch3 equal");
        bus_write(12'h034, 9);
        expect_wave(3, 4, 9, 4'h9, 10, "R7 ch3 above");

        // R4: enable without continuous mode, and mode without enable
        set_nib(0, 4'h1);
        expect_wave(0, 5, 1, 4'h1, 12, "R4 ch0 enable only");
        set_nib(0, 4'h8);
        expect_wave(0, 5, 1, 4'h8, 12, "R4 ch0 mode only");

        // R8: inversion stopped and running
        set_nib(0, 4'h4);
        expect_wave(0, 5, 1, 4'h4, 12, "R8 ch0 stopped inverted");
        set_nib(0, 4'hD);
        expect_wave(0, 5, 1, 4'hD, 12, "R8 ch0 running inverted");
        set_nib(1, 4'hD);
        expect_wave(1, 7, 0, 4'hD, 16, "R8 ch1 invert while running");

        // R3: saturation of oversize values
        set_nib(1, 4'h0);
        bus_write(12'h010, 32'h0001_2345);
        read_check("R3 compare ch0 clamp", 12'h010, 32'h0000_FFFF);
        bus_write(12'h018, 32'h0002_0000);
        read_check("R3 period ch1 clamp", 12'h018, 32'h0000_FFFF);
        set_nib(0, 4'h9);
        expect_wave(0, 5, 65535, 4'h9, 12, "R3 ch0 clamped compare");

        // R9: count register is read-only
        set_nib(0, 4'h0);
        bus_write(12'h014, 32'h55);
        read_check("R9 count write ignored", 12'h014, 0);

        // R11: misaligned accesses
        bus_write(12'h009, 32'hFFFF_FFFF);
        read_check("R11 ctrl after misaligned write", 12'h008, ctrl_v);
        bus_write(12'h00D, 32'h3);
        read_check("R11 period after misaligned write", 12'h00C, 5);
        read_check("R11 misaligned read", 12'h00A, 0);

        // R10: fresh start, then deferred period change
        bus_write(12'h00C, 9);
        bus_write(12'h010, 1);
        set_nib(0, 4'h9);
        read_check("R10 count after start", 12'h014, 1);
        repeat (5) @(negedge clk);
        bus_write(12'h00C, 3);
        mx = 0;
        for (int i = 0; i < 14; i++) begin
            bus_read(12'h014, d);
            if (int'(d) > mx) mx = int'(d);
        end
        check("R10 old period finishes", mx, 9);
        expect_wave(0, 3, 1, 4'h9, 8, "R10 new period applied");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule